// File: doc/BRIEF.md
# DRAM Refresh and Page-Close Timer

This block is the timekeeper of a DDR SDRAM controller. It holds one 32-bit configuration word with two fields. The first is the refresh interval, counted in memory bus clocks. The second is the page-retention time: how many memory bus clocks a row may stay open after its last access. From these fields the block decides when refreshes are due and when an idle open bank should be precharged. The command scheduler that acts on these requests sits outside the block.

Refresh work is offered on a request/acknowledge handshake. Every time the interval elapses, a burst of refreshes is added to a pending count. `refresh_req` acts as a valid signal and stays high while that count is non-zero. Each clock in which `refresh_req` and `refresh_ack` are both high consumes one refresh. An acknowledge while `refresh_req` is low has no effect. The scheduler may hold off `refresh_ack` for as long as it needs, and the pending count saturates so no refresh is lost. Bank accesses arrive on a strobe that is always accepted and has no back-pressure. For each bank there is a retention timer that issues a one-cycle close request when the bank has stayed idle for the programmed time. A retention of zero puts the controller in global auto-precharge mode.

Top module: `dram_maint_timer`

## Requirements
- R1: After reset, `refresh_req` is low, `close_req` is all zeros and `auto_pre` is high, because the configuration word resets to zero.
- R2: The refresh interval is `cfg_wdata[31:16]`, the retention time is `cfg_wdata[13:0]`, and `cfg_wdata[15:14]` has no effect on any output.
- R3: While the interval is zero, `refresh_req` stays low. A write of a zero interval drops `refresh_req` from the cycle after its write edge, and any pending refreshes are discarded.
- R4: If a non-zero interval N is written at clock edge E while refresh is off, refresh events occur at edges E+1+N, E+1+2N, and so on.
- R5: Each refresh event adds `burst_sel`+1 refreshes to the pending count. `refresh_req` is high exactly while that count is non-zero. Each cycle with `refresh_req` and `refresh_ack` both high removes one refresh.
- R6: The pending count saturates at 2^PEND_W-1 and does not wrap.
- R7: A new non-zero interval written while refresh is running does not disturb the countdown in progress. It is used from the next reload onwards.
- R8: An access to bank b at edge A, with retention R>0, restarts that bank's timer. If no further access to b arrives, `close_req[b]` is high for one cycle, right after edge A+R. A later access restarts the count from R.
- R9: If `bank_open[b]` is low at the edge where bank b's timer expires, no close request is issued for that expiry.
- R10: `auto_pre` is high whenever the retention field is zero. While it is high, no close request is issued, including for counts started earlier, and accesses arm no timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: interval [31:16], reserved [15:14], retention [13:0] |
| burst_sel | input | BURST_W | Refreshes per event, minus one |
| refresh_req | output | 1 | Refresh pending (valid side of the handshake) |
| refresh_ack | input | 1 | Scheduler takes one refresh (ready side) |
| acc_valid | input | 1 | Bank access strobe, always accepted |
| acc_bank | input | BANK_W | Bank addressed by the access strobe |
| bank_open | input | NUM_BANKS | Banks that currently hold an open row |
| close_req | output | NUM_BANKS | One-cycle precharge request per bank |
| auto_pre | output | 1 | Global auto-precharge mode in force |

## Verification
The bench measures refresh spacing both on a fresh start and across an interval change made mid-count. A design that reloaded straight away, or that was one cycle off in its countdown, would shift every later event. It withholds acknowledges until the pending count hits its ceiling. A counter that wrapped would then release far fewer than fifteen refreshes. It writes a zero interval while refreshes are pending, which exposes a design that lets a stale request linger or come back. On the bank side it re-accesses a bank mid-count, lets a bank that is not open expire, and switches to auto-precharge while a bank is counting. A timer that ignores restarts, the open flag or the mode change would produce a close request in the wrong cycle or one that should not exist.

// File: rtl/dram_maint_pkg.sv
package dram_maint_pkg;
  localparam int REF_INT_W = 16;
  localparam int RET_W     = 14;
  localparam int CFG_W     = 32;

  // Field order follows the configuration word, most significant first.
  typedef struct packed {
    logic [REF_INT_W-1:0] ref_int;
    logic [1:0]           rsvd;
    logic [RET_W-1:0]     retain;
  } maint_word_t;
endpackage

// File: rtl/dram_maint_cfg.sv
module dram_maint_cfg
  import dram_maint_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [REF_INT_W-1:0] ref_int,
  output logic [RET_W-1:0]     retain,
  output logic                 ref_off_wr,
  output logic                 auto_pre
);
  maint_word_t wr_view;
  logic [REF_INT_W-1:0] ref_int_q;
  logic [RET_W-1:0]     retain_q;

  assign wr_view = maint_word_t'(cfg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_int_q <= '0;
      retain_q  <= '0;
    end else if (cfg_wr) begin
      ref_int_q <= wr_view.ref_int;
      retain_q  <= wr_view.retain;
    end
  end

  assign ref_int    = ref_int_q;
  assign retain     = retain_q;
  // A write that turns refresh off drops pending work on its own edge.
  assign ref_off_wr = cfg_wr && (wr_view.ref_int == '0);
  assign auto_pre   = (retain_q == '0);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_maint_pkg::*;
#(
  parameter int BURST_W = 3,
  parameter int PEND_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REF_INT_W-1:0] ref_int,
  input  logic                 ref_off_wr,
  input  logic [BURST_W-1:0]   burst_sel,
  input  logic                 refresh_ack,
  output logic                 refresh_req
);
  localparam int SUM_W = ((PEND_W > BURST_W) ? PEND_W : BURST_W) + 2;
  localparam logic [SUM_W-1:0] PEND_MAX = SUM_W'((1 << PEND_W) - 1);

  logic [REF_INT_W-1:0] cnt_q;
  logic                 run_q;
  logic [PEND_W-1:0]    pend_q;
  logic                 tick;
  logic                 take;
  logic [SUM_W-1:0]     sum;

  assign tick = run_q && (cnt_q == '0) && (ref_int != '0);
  assign take = refresh_req && refresh_ack;

  always_comb begin
    sum = SUM_W'(pend_q);
    if (tick) sum = sum + SUM_W'(burst_sel) + SUM_W'(1);
    if (take) sum = sum - SUM_W'(1);
  end

  // Interval countdown; a new interval is picked up only on reload.
  always_ff @(posedge clk) begin
    if (!rst_n || ref_int == '0) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      run_q <= 1'b1;
      cnt_q <= ref_int - 1'b1;
    end else if (cnt_q == '0) begin
      cnt_q <= ref_int - 1'b1;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Saturating pending-refresh count.
  always_ff @(posedge clk) begin
    if (!rst_n || ref_off_wr || ref_int == '0) begin
      pend_q <= '0;
    end else if (sum > PEND_MAX) begin
      pend_q <= PEND_MAX[PEND_W-1:0];
    end else begin
      pend_q <= sum[PEND_W-1:0];
    end
  end

  assign refresh_req = (pend_q != '0);
endmodule

// File: rtl/dram_bank_page_timer.sv
module dram_bank_page_timer
  import dram_maint_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RET_W-1:0]     retain,
  input  logic                 auto_pre,
  input  logic                 acc_valid,
  input  logic [BANK_W-1:0]    acc_bank,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] close_req
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [RET_W-1:0] cnt_q;
    logic             armed_q;
    logic             close_q;
    logic             hit;

    assign hit = acc_valid && (acc_bank == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n || auto_pre) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        close_q <= 1'b0;
      end else if (hit) begin
        cnt_q   <= retain - 1'b1;
        armed_q <= 1'b1;
        close_q <= 1'b0;
      end else if (armed_q && cnt_q == '0) begin
        armed_q <= 1'b0;
        close_q <= bank_open[b];
      end else begin
        if (armed_q) cnt_q <= cnt_q - 1'b1;
        close_q <= 1'b0;
      end
    end

    assign close_req[b] = close_q;
  end
endmodule

// File: rtl/dram_maint_timer.sv
module dram_maint_timer
  import dram_maint_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_W   = 3,
  parameter int PEND_W    = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [31:0]          cfg_wdata,
  input  logic [BURST_W-1:0]   burst_sel,
  output logic                 refresh_req,
  input  logic                 refresh_ack,
  input  logic                 acc_valid,
  input  logic [BANK_W-1:0]    acc_bank,
  input  logic [NUM_BANKS-1:0] bank_open,
  output logic [NUM_BANKS-1:0] close_req,
  output logic                 auto_pre
);
  logic [REF_INT_W-1:0] ref_int_q;
  logic [RET_W-1:0]     retain_q;
  logic                 ref_off_wr;

  dram_maint_cfg cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .ref_int    (ref_int_q),
    .retain     (retain_q),
    .ref_off_wr (ref_off_wr),
    .auto_pre   (auto_pre)
  );

  dram_refresh_sched #(.BURST_W(BURST_W), .PEND_W(PEND_W)) sched_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_int     (ref_int_q),
    .ref_off_wr  (ref_off_wr),
    .burst_sel   (burst_sel),
    .refresh_ack (refresh_ack),
    .refresh_req (refresh_req)
  );

  dram_bank_page_timer #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) pages_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .retain    (retain_q),
    .auto_pre  (auto_pre),
    .acc_valid (acc_valid),
    .acc_bank  (acc_bank),
    .bank_open (bank_open),
    .close_req (close_req)
  );
endmodule

// File: rtl/dram_maint_timer_chk.sv
module dram_maint_timer_chk #(
  parameter int NUM_BANKS = 4,
  parameter int INT_W     = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr,
  input logic                 refresh_req,
  input logic                 refresh_ack,
  input logic                 auto_pre,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [NUM_BANKS-1:0] close_req,
  input logic [INT_W-1:0]     ref_int
);
  AST_OFF_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_int == '0) |-> !refresh_req); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack && !cfg_wr) |=> refresh_req); // R5

  AST_CLOSE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (close_req != '0) |-> ((close_req & ~$past(bank_open)) == '0)); // R9

  AST_AUTOPRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |=> (close_req == '0)); // R10
endmodule

bind dram_maint_timer dram_maint_timer_chk #(.NUM_BANKS(NUM_BANKS), .INT_W(16)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .refresh_req (refresh_req),
  .refresh_ack (refresh_ack),
  .auto_pre    (auto_pre),
  .bank_open   (bank_open),
  .close_req   (close_req),
  .ref_int     (ref_int_q)
);

// File: tb/dram_maint_timer_tb_top.sv
module dram_maint_timer_tb_top;
  localparam int NB = 4;
  localparam int BW = 3;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [BW-1:0] burst_sel = '0;
  logic          refresh_ack = 1'b0;
  logic          acc_valid = 1'b0;
  logic [1:0]    acc_bank = '0;
  logic [NB-1:0] bank_open = '1;
  logic          refresh_req;
  logic          auto_pre;
  logic [NB-1:0] close_req;

  dram_maint_timer #(.NUM_BANKS(NB), .BURST_W(BW), .PEND_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .burst_sel(burst_sel), .refresh_req(refresh_req), .refresh_ack(refresh_ack),
    .acc_valid(acc_valid), .acc_bank(acc_bank), .bank_open(bank_open),
    .close_req(close_req), .auto_pre(auto_pre)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  bit sb_ref = 1'b0;
  string ref_tag = "R4";
  int exp_ref[$];
  int exp_cc[$];
  int exp_cb[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Writes take effect on the edge reached when the task returns (cyc then equals that edge).
  task automatic wr(input int ri, input int rsv, input int ret);
    cfg_wdata = {ri[15:0], rsv[1:0], ret[13:0]};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic access(input int b);
    acc_valid = 1'b1;
    acc_bank = b[1:0];
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic push_close(input int c, input int b);
    exp_cc.push_back(c);
    exp_cb.push_back(b);
  endtask

  // Scoreboard monitor: pops expected events as the design produces them.
  always @(negedge clk) begin
    if (sb_ref && refresh_req) begin
      if (exp_ref.size() == 0) check(1'b0, "R3 unexpected refresh_req at cycle", cyc, -1);
      else begin
        int e;
        e = exp_ref.pop_front();
        check(cyc == e, ref_tag, cyc, e);
      end
    end
    for (int b = 0; b < NB; b++) begin
      if (close_req[b]) begin
        if (exp_cc.size() == 0) check(1'b0, "R9/R10 unexpected close_req cycle", cyc, -1);
        else begin
          int ec;
          int eb;
          ec = exp_cc.pop_front();
          eb = exp_cb.pop_front();
          check(cyc == ec, "R8 close_req cycle", cyc, ec);
          check(b == eb, "R8 close_req bank", b, eb);
        end
      end
    end
  end

  initial begin
    int we;
    int ae;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(refresh_req == 1'b0, "R1 refresh_req after reset", refresh_req, 0);
    check(auto_pre == 1'b1, "R1 auto_pre after reset", auto_pre, 1);
    check(close_req == '0, "R1 close_req after reset", close_req, 0);

    // R2 R4: interval 6 in the upper half, one refresh per event, ack always ready
    refresh_ack = 1'b1;
    burst_sel = '0;
    sb_ref = 1'b1;
    ref_tag = "R2 R4 refresh spacing";
    wr(6, 0, 0);
    we = cyc;
    for (int k = 0; k < 4; k++) exp_ref.push_back(we + 7 + 6 * k);
    wait_until(we + 27);
    check(exp_ref.size() == 0, "R4 refresh events missing", exp_ref.size(), 0);
    wr(0, 0, 0);
    repeat (30) @(negedge clk);
    check(refresh_req == 1'b0, "R3 refresh off at zero interval", refresh_req, 0);

    // R7: change interval mid-run
    ref_tag = "R7 interval change at reload";
    wr(10, 0, 0);
    we = cyc;
    exp_ref.push_back(we + 11);
    exp_ref.push_back(we + 21);
    exp_ref.push_back(we + 24);
    exp_ref.push_back(we + 27);
    wait_until(we + 11);
    wr(3, 0, 0);
    wait_until(we + 28);
    wr(0, 0, 0);
    check(exp_ref.size() == 0, "R7 refresh events missing", exp_ref.size(), 0);

    // R5: burst of three with held-off acknowledge
    sb_ref = 1'b0;
    refresh_ack = 1'b0;
    burst_sel = 3'd2;
    wr(200, 0, 0);
    we = cyc;
    while (!refresh_req) @(negedge clk);
    check(cyc == we + 201, "R4 first event cycle", cyc, we + 201);
    refresh_ack = 1'b1;
    n = 0;
    while (refresh_req) begin
      @(negedge clk);
      n++;
    end
    refresh_ack = 1'b0;
    check(n == 3, "R5 refreshes per event", n, 3);
    while (!refresh_req) @(negedge clk);
    repeat (5) @(negedge clk);
    check(refresh_req == 1'b1, "R5 request held without ack", refresh_req, 1);
    wr(0, 0, 0);
    check(refresh_req == 1'b0, "R3 zero write clears pending", refresh_req, 0);
    wr(200, 0, 0);
    repeat (60) @(negedge clk);
    check(refresh_req == 1'b0, "R3 pending stays discarded", refresh_req, 0);
    wr(0, 0, 0);

    // R6: saturation of the pending count
    burst_sel = 3'd7;
    wr(4, 0, 0);
    repeat (30) @(negedge clk);
    wr(16'hFFFF, 0, 0);
    repeat (8) @(negedge clk);
    refresh_ack = 1'b1;
    n = 0;
    while (refresh_req) begin
      @(negedge clk);
      n++;
    end
    refresh_ack = 1'b0;
    check(n == (1 << PW) - 1, "R6 saturated pending count", n, (1 << PW) - 1);
    wr(0, 0, 0);

    // R2 R10: reserved bits and mode flag
    wr(0, 3, 0);
    check(auto_pre == 1'b1, "R2 reserved bits ignored", auto_pre, 1);
    wr(0, 0, 5);
    check(auto_pre == 1'b0, "R10 page mode with retention 5", auto_pre, 0);

    // R8 R9: page-close timing, restart, closed bank
    bank_open = 4'b0111;
    access(1);
    ae = cyc;
    push_close(ae + 5, 1);
    access(2);
    @(negedge clk);
    access(2);
    push_close(cyc + 5, 2);
    access(3);
    repeat (15) @(negedge clk);
    check(exp_cc.size() == 0, "R8 close requests missing", exp_cc.size(), 0);
    check(close_req == '0, "R9 no close for closed bank", close_req, 0);

    // R10: switch to auto-precharge while a bank counts
    bank_open = '1;
    access(0);
    repeat (2) @(negedge clk);
    wr(0, 0, 0);
    repeat (10) @(negedge clk);
    access(0);
    repeat (10) @(negedge clk);
    check(auto_pre == 1'b1, "R10 auto_pre at zero retention", auto_pre, 1);
    check(exp_cc.size() == 0, "R10 no stray expectations", exp_cc.size(), 0);

    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired (R1..R10 run)", cyc, 0);
    report();
  end
endmodule